// File: doc/BRIEF.md
# Port-Size Address Shifter and Lane Router

This block sits between a 32-bit internal word port and an external memory data bus whose useful width may be 8, 16 or 32 bits. An internal access names a word address, a write or read direction, four data bytes and four byte enables. A 3-bit port-size code and an unshifted-address flag are sampled with it. The block turns the access into one, two or four external beats, one beat per clock cycle. For each beat it forms the external address and places the data bytes on the external byte lanes the narrow port is wired to.

Narrow ports may be wired to any byte lane, or to either half of the 32-bit bus. The external address of a beat is the internal byte address of that beat, shifted right by the port's width in bytes unless the unshifted-address flag is set. During reads the beats are gathered into one little-endian internal word. That word is presented together with a one-cycle ready pulse. The external device is assumed to answer every beat within the same cycle, and strobe timing and wait states are handled elsewhere.

Top module: `port_lane_adapter`

## Requirements
- R1: After reset, with no request, `req_ready`, `ext_valid` and `ext_write` are low and `ext_lane_en` is zero.
- R2: An accepted access produces exactly 4 (8-bit port), 2 (16-bit port) or 1 (32-bit port) consecutive `ext_valid` cycles, starting the cycle after acceptance. `req_ready` then rises in the cycle after the last beat and stays high for a single cycle.
- R3: Beat k uses the internal byte address 4*`req_waddr` + k on an 8-bit port, 4*`req_waddr` + 2k on a 16-bit port, and 4*`req_waddr` on a 32-bit port.
- R4: With `cfg_unshift`=0, `ext_addr` is the beat's internal byte address shifted right by 1 for codes 3'b001 and 3'b010 and by 2 for code 3'b011. With `cfg_unshift`=1, no shift is applied.
- R5: `cfg_size` codes map as follows. 3'b000 is an 8-bit port on lane 0 (bits [7:0]). 3'b001 is a 16-bit port on bits [15:0], and 3'b010 is a 16-bit port on bits [31:16]. 3'b011 is a 32-bit port. Codes 3'b100 to 3'b111 are an 8-bit port on lane `cfg_size[1:0]`, where lane n is bits [8n+7:8n]. An 8-bit port is never shifted, whatever `cfg_unshift` holds.
- R6: On an 8-bit port, write beat k carries byte k of `req_wdata` (bits [8k+7:8k]) on the placed lane. Every other lane is zero.
- R7: On a 16-bit port, write beat k carries half-word k of `req_wdata` on the placed half, and the other half is zero. On a 32-bit port, the single beat carries all four bytes on their own lanes.
- R8: On writes, a placed lane's `ext_lane_en` bit equals the `req_be` bit of the internal byte it carries, and a lane whose enable is low carries zero data. On reads, every lane of the placed port is enabled and no others are.
- R9: On reads, byte k (8-bit port) or half-word k (16-bit port) of `rsp_rdata` is taken from the placed lanes of `ext_rdata` in beat k, and unplaced lanes are ignored. `rsp_rdata` is valid while `req_ready` is high, and `ext_wdata` stays zero throughout a read.
- R10: Address, data, byte enables, direction and configuration are captured when the access is accepted. Changes to them before `req_ready` have no effect, and no new access is accepted until the current one has finished.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Internal access request, held until `req_ready` |
| req_write | input | 1 | 1 = write, 0 = read |
| req_waddr | input | ADDR_W-2 | Internal word address (byte address / 4) |
| req_wdata | input | 32 | Internal write data, byte k at bits [8k+7:8k] |
| req_be | input | 4 | Internal byte enables |
| cfg_size | input | 3 | Port size and lane placement code |
| cfg_unshift | input | 1 | 1 = drive the unshifted byte address |
| req_ready | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Gathered read word, valid with `req_ready` |
| ext_valid | output | 1 | External beat active |
| ext_write | output | 1 | External beat is a write |
| ext_addr | output | ADDR_W | External address of the beat |
| ext_lane_en | output | 4 | Per-lane enable of the beat |
| ext_wdata | output | 32 | External write data by lane |
| ext_rdata | input | 32 | External read data by lane, valid during the beat |

## Verification
Every lane placement is exercised for writes: the four single-byte lanes, both halves and the full word. Each write uses data with distinct byte values, so that a wrong beat order, a byte on the wrong lane or a lane left undriven shows up as a wrong byte. Reads are served by a model that puts a different value, depending on address and lane, on every lane of every beat. This separates correct lane extraction from reading a neighbouring lane or a stale beat. Each port width is run with the shift both on and off, to tell the three shift amounts apart. Partial byte enables and inputs disturbed in the middle of an access separate routing of the enables and capture at acceptance from routing of the live inputs.

// File: rtl/plad_pkg.sv
// Shared types for the port-size adapter.
// Assumes a 32-bit internal data bus split into four byte lanes.
package plad_pkg;
    localparam int LANES = 4;

    typedef enum logic [1:0] {
        PW_X8  = 2'd0,
        PW_X16 = 2'd1,
        PW_X32 = 2'd2
    } port_width_e;

    // Decoded port description: width, lane (byte index for x8, half index
    // in bit 0 for x16), address shift and index of the final beat.
    typedef struct packed {
        port_width_e width;
        logic [1:0]  lane;
        logic [1:0]  shamt;
        logic [1:0]  last_beat;
    } port_cfg_t;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_BEAT = 2'd1,
        SQ_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/plad_cfg_decode.sv
// Decodes the 3-bit port size code and the unshifted flag into a port
// description. Purely combinational; assumes the codes listed in the brief.
module plad_cfg_decode
    import plad_pkg::*;
(
    input  logic [2:0] size_code,
    input  logic       unshift,
    output port_cfg_t  cfg
);
    // Map the size code onto width, placement, shift and beat count.
    always_comb begin
        cfg.width     = PW_X8;
        cfg.lane      = 2'd0;
        cfg.shamt     = 2'd0;
        cfg.last_beat = 2'd3;
        if (size_code[2]) begin
            cfg.lane = size_code[1:0];
        end else begin
            case (size_code[1:0])
                2'b01, 2'b10: begin
                    cfg.width     = PW_X16;
                    cfg.lane      = {1'b0, size_code[1]};
                    cfg.shamt     = unshift ? 2'd0 : 2'd1;
                    cfg.last_beat = 2'd1;
                end
                2'b11: begin
                    cfg.width     = PW_X32;
                    cfg.shamt     = unshift ? 2'd0 : 2'd2;
                    cfg.last_beat = 2'd0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/plad_beat_seq.sv
// Beat sequencer: on start it runs beats 0..last_beat, one per cycle,
// then spends one cycle in a done state. Assumes the external side
// completes every beat in a single cycle.
module plad_beat_seq
    import plad_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] last_beat,
    output logic       idle,
    output logic       busy,
    output logic       done,
    output logic [1:0] beat
);
    seq_state_e state;

    // Advance state and beat index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            beat  <= 2'd0;
        end else begin
            case (state)
                SQ_IDLE: if (start) begin
                    state <= SQ_BEAT;
                    beat  <= 2'd0;
                end
                SQ_BEAT: if (beat == last_beat) begin
                    state <= SQ_DONE;
                end else begin
                    beat <= beat + 2'd1;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    // Decode state flags.
    always_comb begin
        idle = (state == SQ_IDLE);
        busy = (state == SQ_BEAT);
        done = (state == SQ_DONE);
    end
endmodule

// File: rtl/plad_addr_map.sv
// Forms the external address of a beat: word base plus the beat's byte
// step, shifted right by the decoded amount.
module plad_addr_map
    import plad_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-3:0] waddr,
    input  port_width_e       width,
    input  logic [1:0]        shamt,
    input  logic [1:0]        beat,
    output logic [ADDR_W-1:0] ext_addr
);
    logic [1:0]        step;
    logic [ADDR_W-1:0] byte_addr;

    // Byte step of the current beat within the word.
    always_comb begin
        case (width)
            PW_X8:   step = beat;
            PW_X16:  step = {beat[0], 1'b0};
            default: step = 2'd0;
        endcase
        byte_addr = {waddr, step};
        ext_addr  = byte_addr >> shamt;
    end
endmodule

// File: rtl/plad_lane_router.sv
// Routes internal bytes to external lanes for writes and external lanes
// back to internal bytes for reads, for the current beat.
// Assumes four lanes; unplaced or disabled lanes carry zero on writes.
module plad_lane_router
    import plad_pkg::*;
(
    input  port_cfg_t         cfg,
    input  logic [1:0]        beat,
    input  logic              wr,
    input  logic [8*LANES-1:0] wdata,
    input  logic [LANES-1:0]  be,
    input  logic [8*LANES-1:0] ext_rdata,
    output logic [8*LANES-1:0] ext_wdata,
    output logic [LANES-1:0]  ext_lane_en,
    output logic [8*LANES-1:0] rd_part,
    output logic [LANES-1:0]  rd_mask
);
    for (genvar j = 0; j < LANES; j++) begin : g_out_lane
        localparam logic [1:0] JJ = 2'(j);
        logic       act;
        logic [1:0] src;
        logic       en;

        // Decide whether external lane j is placed and which byte feeds it.
        always_comb begin
            case (cfg.width)
                PW_X8:  begin act = (cfg.lane == JJ);       src = beat;              end
                PW_X16: begin act = (cfg.lane[0] == JJ[1]); src = {beat[0], JJ[0]};  end
                PW_X32: begin act = 1'b1;                   src = JJ;                end
                default: begin act = 1'b0;                  src = 2'd0;              end
            endcase
            en = act & (wr ? be[src] : 1'b1);
        end

        assign ext_lane_en[j]     = en;
        assign ext_wdata[8*j +: 8] = (wr & en) ? wdata[8*src +: 8] : 8'h00;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_in_byte
        localparam logic [1:0] II = 2'(i);
        logic       hit;
        logic [1:0] lane_sel;

        // Decide whether internal byte i arrives in this beat and on which lane.
        always_comb begin
            case (cfg.width)
                PW_X8:  begin hit = (beat == II);       lane_sel = cfg.lane;              end
                PW_X16: begin hit = (beat[0] == II[1]); lane_sel = {cfg.lane[0], II[0]};  end
                PW_X32: begin hit = 1'b1;               lane_sel = II;                    end
                default: begin hit = 1'b0;              lane_sel = 2'd0;                  end
            endcase
        end

        assign rd_mask[i]        = hit;
        assign rd_part[8*i +: 8] = ext_rdata[8*lane_sel +: 8];
    end
endmodule

// File: rtl/port_lane_adapter.sv
// Top: accepts one 32-bit internal access, captures it with its port
// configuration, runs the external beats and gathers read data.
// Assumes the requester holds req_valid until req_ready and that the
// external device returns read data within each beat cycle.
module port_lane_adapter
    import plad_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-3:0] req_waddr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    input  logic [2:0]        cfg_size,
    input  logic              cfg_unshift,
    output logic              req_ready,
    output logic [31:0]       rsp_rdata,
    output logic              ext_valid,
    output logic              ext_write,
    output logic [ADDR_W-1:0] ext_addr,
    output logic [3:0]        ext_lane_en,
    output logic [31:0]       ext_wdata,
    input  logic [31:0]       ext_rdata
);
    port_cfg_t         live_cfg;
    port_cfg_t         lat_cfg;
    logic [ADDR_W-3:0] lat_waddr;
    logic [31:0]       lat_wdata;
    logic [3:0]        lat_be;
    logic              lat_write;
    logic [31:0]       collect;
    logic              seq_idle, seq_busy, seq_done, start;
    logic [1:0]        beat;
    logic [31:0]       route_wdata, rd_part;
    logic [3:0]        route_en, rd_mask;

    plad_cfg_decode u_dec (
        .size_code (cfg_size),
        .unshift   (cfg_unshift),
        .cfg       (live_cfg)
    );

    assign start = req_valid & seq_idle;

    // Capture the request and its decoded configuration on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_cfg   <= '0;
            lat_waddr <= '0;
            lat_wdata <= '0;
            lat_be    <= '0;
            lat_write <= 1'b0;
        end else if (start) begin
            lat_cfg   <= live_cfg;
            lat_waddr <= req_waddr;
            lat_wdata <= req_wdata;
            lat_be    <= req_be;
            lat_write <= req_write;
        end
    end

    plad_beat_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .last_beat (lat_cfg.last_beat),
        .idle      (seq_idle),
        .busy      (seq_busy),
        .done      (seq_done),
        .beat      (beat)
    );

    plad_addr_map #(.ADDR_W(ADDR_W)) u_addr (
        .waddr    (lat_waddr),
        .width    (lat_cfg.width),
        .shamt    (lat_cfg.shamt),
        .beat     (beat),
        .ext_addr (ext_addr)
    );

    plad_lane_router u_route (
        .cfg         (lat_cfg),
        .beat        (beat),
        .wr          (lat_write),
        .wdata       (lat_wdata),
        .be          (lat_be),
        .ext_rdata   (ext_rdata),
        .ext_wdata   (route_wdata),
        .ext_lane_en (route_en),
        .rd_part     (rd_part),
        .rd_mask     (rd_mask)
    );

    // Gather read bytes beat by beat into the internal word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            collect <= '0;
        end else if (start) begin
            collect <= '0;
        end else if (seq_busy && !lat_write) begin
            for (int i = 0; i < LANES; i++) begin
                if (rd_mask[i]) collect[8*i +: 8] <= rd_part[8*i +: 8];
            end
        end
    end

    // Drive the external beat and internal completion outputs.
    always_comb begin
        ext_valid   = seq_busy;
        ext_write   = seq_busy & lat_write;
        ext_lane_en = seq_busy ? route_en : 4'h0;
        ext_wdata   = seq_busy ? route_wdata : 32'h0;
        req_ready   = seq_done;
        rsp_rdata   = collect;
    end
endmodule

// File: rtl/plad_checker.sv
// Protocol checker for port_lane_adapter, attached by bind below.
// Observes only the top-level ports.
module plad_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              ext_valid,
    input logic              ext_write,
    input logic [ADDR_W-1:0] ext_addr,
    input logic [3:0]        ext_lane_en,
    input logic [31:0]       ext_wdata
);
    logic [2:0]  run;
    logic [31:0] en_mask;

    // Count consecutive beat cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) run <= 3'd0;
        else        run <= ext_valid ? run + 3'd1 : 3'd0;
    end

    // Expand lane enables to a bit mask.
    always_comb begin
        for (int j = 0; j < 4; j++) en_mask[8*j +: 8] = {8{ext_lane_en[j]}};
    end

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_valid |-> (ext_lane_en == 4'h0 && !ext_write && ext_wdata == 32'h0));
    p_ready_after_beat_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!ext_valid && $past(ext_valid)));
    p_ready_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready);
    p_beat_limit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ext_valid |-> (run < 3'd4));
    p_addr_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && $past(ext_valid)) |-> (ext_addr != $past(ext_addr)));
    p_disabled_lane_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && ext_write) |-> ((ext_wdata & ~en_mask) == 32'h0));
    p_read_no_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && !ext_write) |-> (ext_wdata == 32'h0 && ext_lane_en != 4'h0));
    p_dir_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && $past(ext_valid)) |-> (ext_write == $past(ext_write)));
endmodule

bind port_lane_adapter plad_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .ext_valid   (ext_valid),
    .ext_write   (ext_write),
    .ext_addr    (ext_addr),
    .ext_lane_en (ext_lane_en),
    .ext_wdata   (ext_wdata)
);

// File: tb/sim_port_lane_adapter.sv
module sim_port_lane_adapter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, cfg_unshift = 1'b0;
    logic [29:0] req_waddr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic [2:0]  cfg_size = '0;
    logic        req_ready, ext_valid, ext_write;
    logic [31:0] rsp_rdata, ext_addr, ext_wdata, ext_rdata;
    logic [3:0]  ext_lane_en;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    port_lane_adapter #(.ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_waddr(req_waddr), .req_wdata(req_wdata), .req_be(req_be),
        .cfg_size(cfg_size), .cfg_unshift(cfg_unshift), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .ext_valid(ext_valid), .ext_write(ext_write),
        .ext_addr(ext_addr), .ext_lane_en(ext_lane_en), .ext_wdata(ext_wdata),
        .ext_rdata(ext_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a, input int j);
        return (a[7:0] + 8'(j * 64)) ^ 8'h5A;
    endfunction

    // External memory model: a distinct value on every lane.
    always_comb begin
        for (int j = 0; j < 4; j++) ext_rdata[8*j +: 8] = mem_byte(ext_addr, j);
    end

    function automatic void decode(input logic [2:0] s, input logic u,
                                   output int w, output int lane, output int sh);
        if (s[2]) begin w = 8; lane = int'(s[1:0]); sh = 0; end
        else if (s[1:0] == 2'b00) begin w = 8; lane = 0; sh = 0; end
        else if (s[1:0] == 2'b11) begin w = 32; lane = 0; sh = u ? 0 : 2; end
        else begin w = 16; lane = (s[1:0] == 2'b10) ? 1 : 0; sh = u ? 0 : 1; end
    endfunction

    function automatic logic [31:0] beat_addr(input logic [29:0] wa, input int w,
                                              input int sh, input int k);
        logic [31:0] ia;
        ia = {wa, 2'b00} + 32'((w == 8) ? k : (w == 16) ? 2 * k : 0);
        return ia >> sh;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Runs one access, checks every beat and the completion.
    task automatic run_access(input bit wr, input logic [29:0] wa, input logic [31:0] wd,
                              input logic [3:0] be, input logic [2:0] s, input bit u,
                              input bit disturb, input string areq, input string dreq);
        int w, lane, sh, nb, seen, cycles;
        logic [31:0] exp_word;
        decode(s, u, w, lane, sh);
        nb = (w == 8) ? 4 : (w == 16) ? 2 : 1;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_waddr = wa; req_wdata = wd;
        req_be = be; cfg_size = s; cfg_unshift = u;
        seen = 0; cycles = 0;
        @(negedge clk);
        while (!req_ready && cycles < 8) begin
            if (ext_valid) begin
                logic [3:0]  een;
                logic [31:0] edat;
                int k;
                k = seen;
                if (w == 8)       een = wr ? 4'(be[k] << lane) : 4'(1 << lane);
                else if (w == 16) een = wr ? 4'({be[2*k+1], be[2*k]} << (2 * lane)) : 4'(3 << (2 * lane));
                else              een = wr ? be : 4'hF;
                edat = '0;
                for (int j = 0; j < 4; j++) begin
                    int src;
                    src = (w == 8) ? k : (w == 16) ? 2 * k + (j % 2) : j;
                    if (wr && een[j]) edat[8*j +: 8] = wd[8*src +: 8];
                end
                check(ext_addr == beat_addr(wa, w, sh, k), areq, "beat address", ext_addr, beat_addr(wa, w, sh, k));
                check(ext_lane_en == een, "R8", "lane enables", 32'(ext_lane_en), 32'(een));
                check(ext_wdata == edat, dreq, "lane data", ext_wdata, edat);
                check(ext_write == wr, "R10", "beat direction", 32'(ext_write), 32'(wr));
                seen++;
                if (disturb && seen == 1) begin
                    req_waddr = ~wa; req_wdata = ~wd; req_be = ~be;
                    cfg_size = s ^ 3'b011; cfg_unshift = ~u;
                end
            end
            cycles++;
            @(negedge clk);
        end
        check(seen == nb, "R2", "beat count", 32'(seen), 32'(nb));
        check(req_ready == 1'b1, "R2", "ready after beats", 32'(req_ready), 32'd1);
        if (!wr) begin
            for (int i = 0; i < 4; i++) begin
                int b, j;
                b = (w == 8) ? i : (w == 16) ? i / 2 : 0;
                j = (w == 8) ? lane : (w == 16) ? 2 * lane + (i % 2) : i;
                exp_word[8*i +: 8] = mem_byte(beat_addr(wa, w, sh, b), j);
            end
            check(rsp_rdata == exp_word, "R9", "read word", rsp_rdata, exp_word);
        end
        req_valid = 1'b0;
        @(negedge clk);
        check(!req_ready && !ext_valid, "R2", "single ready pulse", 32'({req_ready, ext_valid}), 32'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!req_ready && !ext_valid && !ext_write && ext_lane_en == 4'h0, "R1", "reset outputs",
              32'({req_ready, ext_valid, ext_write, ext_lane_en}), 32'd0);
    endtask

    task automatic t_word_port();
        run_access(1'b1, 30'h0123_4567, 32'hA1B2_C3D4, 4'hF, 3'b011, 1'b0, 1'b0, "R4", "R7");
        run_access(1'b1, 30'h0000_0ABC, 32'h1122_3344, 4'hF, 3'b011, 1'b1, 1'b0, "R4", "R7");
        run_access(1'b0, 30'h0000_0040, 32'h0, 4'hF, 3'b011, 1'b0, 1'b0, "R4", "R9");
    endtask

    task automatic t_half_port();
        run_access(1'b1, 30'h0000_1235, 32'hDEAD_BEEF, 4'hF, 3'b001, 1'b0, 1'b0, "R3", "R7");
        run_access(1'b1, 30'h0000_0777, 32'h5566_7788, 4'hF, 3'b010, 1'b1, 1'b0, "R4", "R7");
        run_access(1'b0, 30'h0000_0013, 32'h0, 4'hF, 3'b010, 1'b0, 1'b0, "R3", "R9");
    endtask

    task automatic t_byte_lanes();
        run_access(1'b1, 30'h0000_0201, 32'h8877_6655, 4'hF, 3'b000, 1'b0, 1'b0, "R3", "R6");
        for (int c = 4; c < 8; c++)
            run_access(1'b1, 30'h0000_0300 + 30'(c), 32'hF0E1_D2C3, 4'hF, 3'(c), 1'b0, 1'b0, "R5", "R6");
    endtask

    task automatic t_partial_enables();
        run_access(1'b1, 30'h0000_0456, 32'h0BAD_F00D, 4'b0110, 3'b001, 1'b0, 1'b0, "R4", "R8");
        run_access(1'b1, 30'h0000_0457, 32'hCAFE_1234, 4'b1010, 3'b110, 1'b0, 1'b0, "R5", "R8");
    endtask

    task automatic t_reads();
        run_access(1'b0, 30'h0000_0021, 32'h0, 4'hF, 3'b110, 1'b0, 1'b0, "R5", "R9");
        run_access(1'b0, 30'h0000_0035, 32'h0, 4'hF, 3'b001, 1'b1, 1'b0, "R4", "R9");
        run_access(1'b0, 30'h0000_0009, 32'h0, 4'hF, 3'b000, 1'b1, 1'b0, "R5", "R9");
    endtask

    task automatic t_capture();
        run_access(1'b1, 30'h0000_0666, 32'h1357_9BDF, 4'hF, 3'b001, 1'b0, 1'b1, "R10", "R10");
        run_access(1'b0, 30'h0000_0088, 32'h0, 4'hF, 3'b101, 1'b0, 1'b1, "R10", "R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_word_port();
        t_half_port();
        t_byte_lanes();
        t_partial_enables();
        t_reads();
        t_capture();
        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule